// File: doc/BRIEF.md
# Fuse Array Read Controller

This block sits on a simple register bus and fronts a small one-time-programmable fuse array of 32 blocks, each 16 bits wide. Software sets a block number, writes a start bit and then polls a status word. When the read completes, software collects the data word and clears the done flag. Programming of fuses is not implemented. The array itself is a behavioural ROM whose content is computed from parameters.

An external module-enable input gates the whole controller. While it is low, the controller stays in a disabled state and reports no flags. When it rises, the controller moves to standby one cycle later. A read is accepted only in standby. The read holds the busy flag for a programmable number of cycles, then stores the block in the read-data register and raises a sticky done flag. That flag stays set until software writes a clear bit.

Top module: `efuse_rd_ctrl`

## Requirements
- R1: After reset, and while `mod_en_i` is low, the status word (offset 0x14) reads 0 and the read-data word (offset 0x04) reads 0. One cycle after `mod_en_i` rises, status reads 0x4 (standby, bit 2).
- R2: The block-number register (offset 0x0C) keeps only bits [4:0] and reads back with its upper bits zero. A read uses only those five bits.
- R3: A write with bit 1 set to the mode word (offset 0x10), made in standby, starts a read. During the read, status reads 0x2 (busy, bit 1, with standby clear). After the timing count has elapsed, status reads 0x10 (done, bit 4).
- R4: When a read completes, the read-data word holds the selected block zero-extended to 32 bits. Block k holds (0x5A3C XOR (k × 0x1111)) mod 2^16.
- R5: The done flag stays set until a write with bit 2 set to the mode word. After that write, status reads 0x4 again.
- R6: A start written while the controller is busy, done or disabled is ignored. It launches no read, and it does not change the block being read.
- R7: Dropping `mod_en_i` puts the controller in the disabled state at the next edge, with status 0. Any read in progress is abandoned without raising done.
- R8: The read lasts N cycles, where N is the value of the read-timing register (offset 0x24). A value of 0 gives one cycle.
- R9: A clear written in a cycle when the controller is not yet in the done state, including the cycle in which a read completes, has no effect. Done is still raised afterwards.
- R10: The words at offsets 0x00, 0x08, 0x20, 0x24 and 0x28 read back what was written. The mode word always reads 0. Mode bit 0 (programming start) has no effect on status.
- R11: The read-data word keeps its value until the next completed read. A clear, a disable or an ignored start does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_en_i | input | 1 | Module enable from the global enable register |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as a read strobe, 0 otherwise |

## Verification
A clear of the done flag and the completion of a read can fall in the same cycle. The bench provokes this by counting cycles from the start write, with a read timing of 3, and placing the clear write on the exact edge where the count expires. The clear must be lost: the next status sample must show done, and a second clear must then return the controller to standby. A start that lands while the controller is busy or disabled is provoked in the same way. It is judged by the data that finally arrives and by the status flags.

// File: rtl/efuse_pkg.sv
package efuse_pkg;
  localparam logic [5:0] A_GLB  = 6'h00;
  localparam logic [5:0] A_RDAT = 6'h04;
  localparam logic [5:0] A_WDAT = 6'h08;
  localparam logic [5:0] A_BIDX = 6'h0C;
  localparam logic [5:0] A_MODE = 6'h10;
  localparam logic [5:0] A_STAT = 6'h14;
  localparam logic [5:0] A_WTIM = 6'h20;
  localparam logic [5:0] A_RTIM = 6'h24;
  localparam logic [5:0] A_DEB  = 6'h28;

  localparam int unsigned MODE_RD  = 1;
  localparam int unsigned MODE_CLR = 2;

  localparam int unsigned ST_RBUSY = 1;
  localparam int unsigned ST_STBY  = 2;
  localparam int unsigned ST_DONE  = 4;
  localparam int unsigned ST_W     = 5;

  typedef enum logic [1:0] {S_OFF, S_STBY, S_BUSY, S_DONE} rd_state_e;
endpackage

// File: rtl/efuse_rom.sv
module efuse_rom #(
  parameter int unsigned NBLK  = 32,
  parameter int unsigned BLK_W = 16,
  parameter logic [BLK_W-1:0] SEED = 16'h5A3C,
  parameter int unsigned STEP  = 32'h1111,
  localparam int unsigned IDX_W = $clog2(NBLK)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [BLK_W-1:0] data_o
);
  logic [BLK_W-1:0] rom [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    assign rom[g] = SEED ^ BLK_W'(g * STEP);
  end

  assign data_o = rom[idx_i];
endmodule

// File: rtl/efuse_rd_fsm.sv
module efuse_rd_fsm
  import efuse_pkg::*;
#(
  parameter int unsigned NBLK  = 32,
  parameter int unsigned TIM_W = 16,
  localparam int unsigned IDX_W = $clog2(NBLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] bidx_i,
  input  logic [TIM_W-1:0] cycles_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             cap_o,
  output logic [ST_W-1:0]  status_o
);
  rd_state_e        state_q;
  logic [TIM_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OFF;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (!en_i) begin
      state_q <= S_OFF;
    end else begin
      case (state_q)
        S_OFF:  state_q <= S_STBY;
        S_STBY: if (start_i) begin
          state_q <= S_BUSY;
          cnt_q   <= cycles_i;
          idx_q   <= bidx_i;
        end
        S_BUSY: begin
          if (cnt_q == TIM_W'(1)) state_q <= S_DONE;
          else                    cnt_q   <= cnt_q - TIM_W'(1);
        end
        S_DONE: if (clr_i) state_q <= S_STBY;
        default: state_q <= S_OFF;
      endcase
    end
  end

  assign cap_o    = en_i && (state_q == S_BUSY) && (cnt_q == TIM_W'(1));
  assign rd_idx_o = idx_q;

  always_comb begin
    status_o           = '0;
    status_o[ST_STBY]  = (state_q == S_STBY);
    status_o[ST_RBUSY] = (state_q == S_BUSY);
    status_o[ST_DONE]  = (state_q == S_DONE);
  end

  // R7
  a_r7_disable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == S_OFF);
  // R5
  a_r5_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == S_DONE && !clr_i) |=> state_q == S_DONE);
  // R6
  a_r6_busy_keeps_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == S_BUSY && cnt_q != TIM_W'(1)) |=> (state_q == S_BUSY && $stable(idx_q)));
  // R9
  a_r9_clr_early_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == S_BUSY && clr_i) |=> state_q != S_STBY);
  // R3
  a_r3_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o));
  // R8
  a_r8_cnt_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_BUSY |-> cnt_q != '0);
endmodule

// File: rtl/efuse_regs.sv
module efuse_regs
  import efuse_pkg::*;
#(
  parameter int unsigned NBLK   = 32,
  parameter int unsigned BLK_W  = 16,
  parameter int unsigned TIM_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned IDX_W = $clog2(NBLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [ST_W-1:0]   status_i,
  input  logic              cap_i,
  input  logic [BLK_W-1:0]  cap_data_i,
  output logic              start_o,
  output logic              clr_o,
  output logic [IDX_W-1:0]  bidx_o,
  output logic [TIM_W-1:0]  cycles_o
);
  logic [DATA_W-1:0] glb_q, wdat_q, deb_q, data_q;
  logic [TIM_W-1:0]  wtim_q, rtim_q;
  logic [IDX_W-1:0]  bidx_q;
  logic              wr, mode_wr;

  assign wr      = req_i && we_i;
  assign mode_wr = wr && (addr_i == ADDR_W'(A_MODE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q  <= '0;
      wdat_q <= '0;
      deb_q  <= '0;
      wtim_q <= '0;
      rtim_q <= TIM_W'(1);
      bidx_q <= '0;
    end else if (wr) begin
      case (addr_i)
        ADDR_W'(A_GLB):  glb_q  <= wdata_i;
        ADDR_W'(A_WDAT): wdat_q <= wdata_i;
        ADDR_W'(A_DEB):  deb_q  <= wdata_i;
        ADDR_W'(A_WTIM): wtim_q <= wdata_i[TIM_W-1:0];
        ADDR_W'(A_RTIM): rtim_q <= wdata_i[TIM_W-1:0];
        ADDR_W'(A_BIDX): bidx_q <= wdata_i[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_q <= '0;
    else if (cap_i) data_q <= DATA_W'(cap_data_i);
  end

  assign start_o  = mode_wr && wdata_i[MODE_RD];
  assign clr_o    = mode_wr && wdata_i[MODE_CLR];
  assign bidx_o   = bidx_q;
  assign cycles_o = (rtim_q == '0) ? TIM_W'(1) : rtim_q;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (addr_i)
        ADDR_W'(A_GLB):  rdata_o = glb_q;
        ADDR_W'(A_RDAT): rdata_o = data_q;
        ADDR_W'(A_WDAT): rdata_o = wdat_q;
        ADDR_W'(A_BIDX): rdata_o = DATA_W'(bidx_q);
        ADDR_W'(A_STAT): rdata_o = DATA_W'(status_i);
        ADDR_W'(A_WTIM): rdata_o = DATA_W'(wtim_q);
        ADDR_W'(A_RTIM): rdata_o = DATA_W'(rtim_q);
        ADDR_W'(A_DEB):  rdata_o = deb_q;
        default:         rdata_o = '0;
      endcase
    end
  end

  // R11
  a_r11_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(data_q));
  // R4
  a_r4_cap_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> data_q == DATA_W'($past(cap_data_i)));
endmodule

// File: rtl/efuse_rd_ctrl.sv
module efuse_rd_ctrl
  import efuse_pkg::*;
#(
  parameter int unsigned NBLK   = 32,
  parameter int unsigned BLK_W  = 16,
  parameter int unsigned TIM_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mod_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IDX_W = $clog2(NBLK);

  logic [ST_W-1:0]  status;
  logic             cap, start, clr;
  logic [IDX_W-1:0] bidx, rd_idx;
  logic [TIM_W-1:0] cycles;
  logic [BLK_W-1:0] rom_data;

  efuse_regs #(
    .NBLK(NBLK), .BLK_W(BLK_W), .TIM_W(TIM_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .status_i(status), .cap_i(cap), .cap_data_i(rom_data),
    .start_o(start), .clr_o(clr), .bidx_o(bidx), .cycles_o(cycles)
  );

  efuse_rd_fsm #(.NBLK(NBLK), .TIM_W(TIM_W)) u_fsm (
    .clk_i, .rst_ni, .en_i(mod_en_i), .start_i(start), .clr_i(clr),
    .bidx_i(bidx), .cycles_i(cycles), .rd_idx_o(rd_idx), .cap_o(cap),
    .status_o(status)
  );

  efuse_rom #(.NBLK(NBLK), .BLK_W(BLK_W)) u_rom (
    .idx_i(rd_idx), .data_o(rom_data)
  );
endmodule

// File: tb/sim_efuse_rd_ctrl.sv
`timescale 1ns/1ps
module sim_efuse_rd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int nchk = 0;
  int nerr = 0;
  bit done_run = 1'b0;
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];

  always #10 clk = ~clk;

  efuse_rd_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(mod_en), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [31:0] blk_val(int k);
    logic [31:0] p;
    p = 32'(k) * 32'h1111;
    return {16'h0, 16'h5A3C ^ p[15:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; write captured at the next posedge, returns at the following negedge
  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic poll_done(string tag);
    logic [31:0] s;
    bit seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      bus_rd(6'h14, s);
      if (s[4]) begin seen = 1'b1; break; end
    end
    check(tag, 32'(seen), 32'd1);
  endtask

  // driver: pushes expected, runs the handshake, hands the fetched word to the monitor
  task automatic sb_read(logic [31:0] idx_wr, logic [31:0] tim);
    logic [31:0] d;
    bus_wr(6'h24, tim);
    bus_wr(6'h0C, idx_wr);
    exp_q.push_back(blk_val(int'(idx_wr[4:0])));
    bus_wr(6'h10, 32'h2);
    poll_done("R3 done seen");
    bus_rd(6'h04, d);
    act_q.push_back(d);
    bus_wr(6'h10, 32'h4);
  endtask

  // monitor
  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0)
      check("R4 scoreboard data", act_q.pop_front(), exp_q.pop_front());
  end

  initial begin : watchdog
    #(20 * 150000);
    if (!done_run) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] st [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset / disabled
    bus_rd(6'h14, d); check("R1 status disabled", d, 32'h0);
    bus_rd(6'h04, d); check("R1 data reset", d, 32'h0);
    mod_en = 1'b1;
    @(negedge clk);
    bus_rd(6'h14, d); check("R1 standby after enable", d, 32'h4);

    // R10 plain storage
    bus_wr(6'h00, 32'hDEADBEEF); bus_rd(6'h00, d); check("R10 glb", d, 32'hDEADBEEF);
    bus_wr(6'h08, 32'h12345678); bus_rd(6'h08, d); check("R10 wdat", d, 32'h12345678);
    bus_wr(6'h20, 32'h0000ABCD); bus_rd(6'h20, d); check("R10 wtim", d, 32'h0000ABCD);
    bus_wr(6'h28, 32'hCAFE0001); bus_rd(6'h28, d); check("R10 deb", d, 32'hCAFE0001);
    bus_wr(6'h10, 32'h1);
    bus_rd(6'h10, d); check("R10 mode reads 0", d, 32'h0);
    bus_rd(6'h14, d); check("R10 pgm start no effect", d, 32'h4);

    // R2 index masking
    bus_wr(6'h0C, 32'hFFFF_FFE5); bus_rd(6'h0C, d); check("R2 index mask", d, 32'h5);

    // R3 cycle timing with N=3, block 7
    bus_wr(6'h24, 32'd3); bus_rd(6'h24, d); check("R10 rtim", d, 32'd3);
    bus_wr(6'h0C, 32'd7);
    bus_wr(6'h10, 32'h2);
    for (int i = 0; i < 4; i++) bus_rd(6'h14, st[i]);
    check("R3 busy first", st[0], 32'h2);
    check("R3 busy last", st[2], 32'h2);
    check("R3 done after N", st[3], 32'h10);
    bus_rd(6'h04, d); check("R4 block 7", d, blk_val(7));
    bus_wr(6'h0C, 32'd9);
    bus_wr(6'h10, 32'h2);
    bus_rd(6'h14, d); check("R6 start in done ignored", d, 32'h10);
    bus_rd(6'h04, d); check("R11 data kept after ignored start", d, blk_val(7));
    bus_wr(6'h10, 32'h4);
    bus_rd(6'h14, d); check("R5 clear to standby", d, 32'h4);
    bus_rd(6'h04, d); check("R11 data kept after clear", d, blk_val(7));

    // R8 zero timing gives one cycle
    bus_wr(6'h24, 32'd0);
    bus_wr(6'h10, 32'h2);
    bus_rd(6'h14, st[0]);
    bus_rd(6'h14, st[1]);
    check("R8 busy one cycle", st[0], 32'h2);
    check("R8 done after one", st[1], 32'h10);
    bus_wr(6'h10, 32'h4);

    // scoreboard reads, several patterns
    sb_read(32'd0, 32'd5);
    sb_read(32'd31, 32'd2);
    sb_read(32'd12, 32'd0);
    sb_read(32'h25, 32'd4);   // R2: upper bits dropped -> block 5

    // R6 start and index change while busy
    bus_wr(6'h24, 32'd6);
    bus_wr(6'h0C, 32'd3);
    bus_wr(6'h10, 32'h2);
    bus_wr(6'h0C, 32'd9);
    bus_wr(6'h10, 32'h2);
    poll_done("R6 done seen");
    bus_rd(6'h04, d); check("R6 busy start ignored", d, blk_val(3));
    bus_wr(6'h10, 32'h4);

    // R9 clear collides with completion edge
    bus_wr(6'h24, 32'd3);
    bus_wr(6'h0C, 32'd10);
    bus_wr(6'h10, 32'h2);
    repeat (2) @(negedge clk);
    bus_wr(6'h10, 32'h4);
    bus_rd(6'h14, d); check("R9 clear at completion lost", d, 32'h10);
    bus_rd(6'h04, d); check("R4 block 10", d, blk_val(10));
    bus_wr(6'h10, 32'h4);
    bus_rd(6'h14, d); check("R9 later clear works", d, 32'h4);

    // R7 disable mid-read
    bus_wr(6'h24, 32'd10);
    bus_wr(6'h0C, 32'd20);
    bus_wr(6'h10, 32'h2);
    bus_rd(6'h14, d); check("R7 busy before drop", d, 32'h2);
    mod_en = 1'b0;
    @(negedge clk);
    bus_rd(6'h14, d); check("R7 status off", d, 32'h0);
    bus_wr(6'h10, 32'h2);
    repeat (12) @(negedge clk);
    bus_rd(6'h14, d); check("R6 start while disabled ignored", d, 32'h0);
    bus_rd(6'h04, d); check("R7 abandoned read keeps data", d, blk_val(10));
    mod_en = 1'b1;
    @(negedge clk);
    bus_rd(6'h14, d); check("R7 standby after re-enable", d, 32'h4);
    bus_rd(6'h04, d); check("R11 data kept across disable", d, blk_val(10));

    repeat (4) @(negedge clk);
    check("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule